// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This block holds the three control registers a processor core needs to enter and leave an exception handler: a saved return address, a status word carrying the global interrupt enable, and a cause word that records why the handler was entered and which devices are waiting. It watches the instruction-completion strobe from the core. When an instruction completes while a request is pending, the next instruction is not started. The unit saves that instruction's address, masks further interrupts and steers fetch to one fixed handler address.

Handler software reads the cause word to find the device that needs service, because there is one common handler entry point and no per-device dispatch. Software moves data in and out of the registers by register number. It signals devices with a single-cycle acknowledge so that they lower their request line. When it is done, it issues a return request that sends fetch back to the saved address and re-enables interrupts.

Top module: `trap_ctrl`

## Requirements
- R1: After reset, `redirect` and `iack` are 0, and reading register numbers 12, 13 and 14 returns 0.
- R2: Register numbers select the registers: 14 is the saved return address (all 32 bits writable and readable), and 12 is the status word, where only bit 0 (interrupt enable) is stored and the other bits read 0. Reads of any other number return 0, and writes to any other number change nothing.
- R3: A device interrupt is taken only in a cycle where `instr_done`, `dev_irq` and the interrupt enable are all 1. In the following cycle, `redirect` is 1 and `redirect_pc` equals `HANDLER_PC` (default 0x80000180).
- R4: On every exception entry, register 14 is loaded with `next_pc` as sampled in the entry cycle.
- R5: Every exception entry clears the interrupt enable (status bit 0).
- R6: An overflow exception (`ovf_exc` high together with `instr_done`) is taken whatever the interrupt enable holds, redirects to `HANDLER_PC`, and sets cause bits 7:0 to 0x30. A device interrupt entry sets cause bits 7:0 to 0x00.
- R7: A 1 on `dev_pend[i]` sets cause bit 8+i, and the bit stays set. Writing register 13 clears each pending bit written as 1 and leaves the bits written as 0 alone. A set and a clear of the same bit in one cycle leave it set. Cause bits 7:0 ignore writes.
- R8: An `eret` request in a cycle with no exception entry gives `redirect`=1 and `redirect_pc` equal to register 14 in the following cycle, and sets the interrupt enable back to 1 at the same edge.
- R9: When an exception entry and `eret` fall in the same cycle, the entry wins: fetch goes to `HANDLER_PC` and the interrupt enable ends at 0.
- R10: A rising edge on `ack_cmd` produces `iack`=1 for exactly the next cycle. Holding `ack_cmd` high produces no further pulse.
- R11: `redirect` is a single-cycle pulse. It is never raised unless an entry or a return was requested in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_done | input | 1 | Current instruction completes this cycle (instruction boundary) |
| next_pc | input | 32 | Address of the instruction that would follow |
| dev_irq | input | 1 | Shared device interrupt request line |
| dev_pend | input | 8 | Per-device pending set strobes |
| ovf_exc | input | 1 | Signed-add overflow from the completing instruction |
| reg_we | input | 1 | Move-to register write strobe |
| reg_wnum | input | 5 | Register number for the write |
| reg_wdata | input | 32 | Write data |
| reg_rnum | input | 5 | Register number for the move-from read |
| reg_rdata | output | 32 | Read data (combinational) |
| eret | input | 1 | Exception return request |
| ack_cmd | input | 1 | Software acknowledge command |
| iack | output | 1 | One-cycle acknowledge pulse to devices |
| redirect | output | 1 | Fetch redirect strobe |
| redirect_pc | output | 32 | Fetch redirect target |

## Verification
Device requests are raised with the enable clear, with the enable set but no completed instruction, and with all conditions met. This shows that the boundary and the mask each gate entry. An overflow entry is made with interrupts masked, which separates the overflow path from the masked interrupt path and shows its distinct cause code. A return is issued both alone and together with an entry, which shows the return target and the priority of entry over return. Pending bits are cleared with selective masks and with a set in the same cycle, which shows write-one-to-clear apart from a plain overwrite.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [4:0] RN_STATUS = 5'd12;
  localparam logic [4:0] RN_CAUSE  = 5'd13;
  localparam logic [4:0] RN_EPC    = 5'd14;
  localparam logic [7:0] CODE_IRQ  = 8'h00;
  localparam logic [7:0] CODE_OVF  = 8'h30;
  typedef enum logic [1:0] {EV_NONE = 2'd0, EV_IRQ = 2'd1, EV_OVF = 2'd2} trap_ev_e;
endpackage

// File: rtl/trap_seq.sv
module trap_seq
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h8000_0180
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_done,
  input  logic            dev_irq,
  input  logic            ovf_exc,
  input  logic            ie,
  input  logic            eret,
  input  logic [XLEN-1:0] epc,
  output trap_ev_e        ev,
  output logic            ret_go,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc
);
  logic            redir_d;
  logic [XLEN-1:0] pc_d;
  logic            redir_q;
  logic [XLEN-1:0] pc_q;

  always_comb begin
    ev = EV_NONE;
    if (instr_done && ovf_exc)            ev = EV_OVF;
    else if (instr_done && dev_irq && ie) ev = EV_IRQ;
    ret_go  = eret && (ev == EV_NONE);
    redir_d = (ev != EV_NONE) || ret_go;
    pc_d    = (ev != EV_NONE) ? HANDLER_PC : epc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_q <= 1'b0;
      pc_q    <= '0;
    end else begin
      redir_q <= redir_d;
      if (redir_d) pc_q <= pc_d;
    end
  end

  assign redirect    = redir_q;
  assign redirect_pc = pc_q;
endmodule

// File: rtl/trap_regfile.sv
module trap_regfile
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NDEV = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  trap_ev_e        ev,
  input  logic            ret_go,
  input  logic [XLEN-1:0] next_pc,
  input  logic [NDEV-1:0] dev_pend,
  input  logic            wr_en,
  input  logic [4:0]      wr_num,
  input  logic [XLEN-1:0] wr_data,
  input  logic [4:0]      rd_num,
  output logic [XLEN-1:0] rd_data,
  output logic            ie,
  output logic [XLEN-1:0] epc
);
  localparam int unsigned PEND_LO = 8;
  localparam int unsigned PEND_HI = PEND_LO + NDEV;

  logic [XLEN-1:0] epc_q, epc_d;
  logic            ie_q, ie_d;
  logic [7:0]      code_q, code_d;
  logic [NDEV-1:0] pend_q, pend_d;

  always_comb begin
    epc_d  = epc_q;
    ie_d   = ie_q;
    code_d = code_q;
    pend_d = pend_q;
    if (wr_en && wr_num == RN_EPC)    epc_d = wr_data;
    if (wr_en && wr_num == RN_STATUS) ie_d  = wr_data[0];
    if (wr_en && wr_num == RN_CAUSE)  pend_d = pend_q & ~wr_data[PEND_LO +: NDEV];
    pend_d = pend_d | dev_pend;
    if (ret_go) ie_d = 1'b1;
    if (ev != EV_NONE) begin
      epc_d  = next_pc;
      ie_d   = 1'b0;
      code_d = (ev == EV_OVF) ? CODE_OVF : CODE_IRQ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q  <= '0;
      ie_q   <= 1'b0;
      code_q <= '0;
      pend_q <= '0;
    end else begin
      epc_q  <= epc_d;
      ie_q   <= ie_d;
      code_q <= code_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_num)
      RN_EPC:    rd_data = epc_q;
      RN_STATUS: rd_data[0] = ie_q;
      RN_CAUSE: begin
        rd_data[7:0]            = code_q;
        rd_data[PEND_HI-1:PEND_LO] = pend_q;
      end
      default:   rd_data = '0;
    endcase
  end

  assign ie  = ie_q;
  assign epc = epc_q;
endmodule

// File: rtl/trap_ack.sv
module trap_ack (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_cmd,
  output logic iack
);
  logic cmd_q, iack_q, iack_d;

  always_comb iack_d = ack_cmd && !cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= 1'b0;
      iack_q <= 1'b0;
    end else begin
      cmd_q  <= ack_cmd;
      iack_q <= iack_d;
    end
  end

  assign iack = iack_q;
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NDEV = 8,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h8000_0180
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_done,
  input  logic [XLEN-1:0] next_pc,
  input  logic            dev_irq,
  input  logic [NDEV-1:0] dev_pend,
  input  logic            ovf_exc,
  input  logic            reg_we,
  input  logic [4:0]      reg_wnum,
  input  logic [XLEN-1:0] reg_wdata,
  input  logic [4:0]      reg_rnum,
  output logic [XLEN-1:0] reg_rdata,
  input  logic            eret,
  input  logic            ack_cmd,
  output logic            iack,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc
);
  trap_ev_e        ev_w;
  logic            ret_w;
  logic            ie_w;
  logic [XLEN-1:0] epc_w;

  trap_seq #(.XLEN(XLEN), .HANDLER_PC(HANDLER_PC)) u_seq (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .dev_irq(dev_irq),
    .ovf_exc(ovf_exc), .ie(ie_w), .eret(eret), .epc(epc_w), .ev(ev_w),
    .ret_go(ret_w), .redirect(redirect), .redirect_pc(redirect_pc)
  );

  trap_regfile #(.XLEN(XLEN), .NDEV(NDEV)) u_regs (
    .clk(clk), .rst_n(rst_n), .ev(ev_w), .ret_go(ret_w), .next_pc(next_pc),
    .dev_pend(dev_pend), .wr_en(reg_we), .wr_num(reg_wnum), .wr_data(reg_wdata),
    .rd_num(reg_rnum), .rd_data(reg_rdata), .ie(ie_w), .epc(epc_w)
  );

  trap_ack u_ack (.clk(clk), .rst_n(rst_n), .ack_cmd(ack_cmd), .iack(iack));
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk #(
  parameter int unsigned XLEN = 32,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h8000_0180
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_done,
  input logic [XLEN-1:0] next_pc,
  input logic            dev_irq,
  input logic            ovf_exc,
  input logic            eret,
  input logic            iack,
  input logic            redirect,
  input logic [XLEN-1:0] redirect_pc,
  input logic            ie,
  input logic [XLEN-1:0] epc
);
  AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && dev_irq && ie) |=> (redirect && redirect_pc == HANDLER_PC)); // R3
  AST_EPC_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && (ovf_exc || (dev_irq && ie))) |=> (epc == $past(next_pc))); // R4
  AST_IE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && (ovf_exc || (dev_irq && ie))) |=> !ie); // R5
  AST_OVF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && ovf_exc) |=> (redirect && redirect_pc == HANDLER_PC)); // R6
  AST_ERET_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !instr_done) |=> (redirect && ie && redirect_pc == $past(epc))); // R8
  AST_IACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    iack |=> !iack); // R10
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_done && !eret) |=> !redirect); // R11
endmodule

bind trap_ctrl trap_ctrl_chk #(.XLEN(XLEN), .HANDLER_PC(HANDLER_PC)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .next_pc(next_pc),
  .dev_irq(dev_irq), .ovf_exc(ovf_exc), .eret(eret), .iack(iack),
  .redirect(redirect), .redirect_pc(redirect_pc), .ie(ie_w), .epc(epc_w)
);

// File: tb/trap_ctrl_tb.sv
module trap_ctrl_tb;
  localparam logic [31:0] HND = 32'h8000_0180;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_done = 1'b0;
  logic [31:0] next_pc = '0;
  logic        dev_irq = 1'b0;
  logic [7:0]  dev_pend = '0;
  logic        ovf_exc = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_wnum = '0;
  logic [31:0] reg_wdata = '0;
  logic [4:0]  reg_rnum = '0;
  logic [31:0] reg_rdata;
  logic        eret = 1'b0;
  logic        ack_cmd = 1'b0;
  logic        iack, redirect;
  logic [31:0] redirect_pc;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  trap_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .next_pc(next_pc),
    .dev_irq(dev_irq), .dev_pend(dev_pend), .ovf_exc(ovf_exc), .reg_we(reg_we),
    .reg_wnum(reg_wnum), .reg_wdata(reg_wdata), .reg_rnum(reg_rnum),
    .reg_rdata(reg_rdata), .eret(eret), .ack_cmd(ack_cmd), .iack(iack),
    .redirect(redirect), .redirect_pc(redirect_pc)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // advance one edge; inputs change 1 ns after the edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [4:0] num, output logic [31:0] v);
    reg_rnum = num;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [4:0] num, input logic [31:0] d);
    reg_we = 1'b1; reg_wnum = num; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 redirect", {31'd0, redirect}, 32'd0);
    chk("R1 iack", {31'd0, iack}, 32'd0);
    rd(5'd12, v); chk("R1 status", v, 32'd0);
    rd(5'd13, v); chk("R1 cause", v, 32'd0);
    rd(5'd14, v); chk("R1 epc", v, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(5'd14, 32'h1234_5678);
    rd(5'd14, v); chk("R2 epc rw", v, 32'h1234_5678);
    wr(5'd12, 32'hFFFF_FFFF);
    rd(5'd12, v); chk("R2 status only bit0", v, 32'd1);
    wr(5'd12, 32'h0000_0000);
    rd(5'd12, v); chk("R2 status clear", v, 32'd0);
    wr(5'd5, 32'hDEAD_BEEF);
    rd(5'd5, v); chk("R2 other reads 0", v, 32'd0);
    rd(5'd14, v); chk("R2 other write no effect", v, 32'h1234_5678);
  endtask

  task automatic t_irq_masked();
    dev_irq = 1'b1; instr_done = 1'b1; next_pc = 32'h40;
    tick();
    chk("R3 masked no redirect", {31'd0, redirect}, 32'd0);
    instr_done = 1'b0;
    wr(5'd12, 32'd1);
    tick();
    chk("R3 no boundary no redirect", {31'd0, redirect}, 32'd0);
    dev_irq = 1'b0;
  endtask

  task automatic t_irq_taken();
    logic [31:0] v;
    dev_pend = 8'h04;
    tick();
    dev_pend = 8'h00;
    dev_irq = 1'b1; instr_done = 1'b1; next_pc = 32'h0040_0010;
    tick();
    instr_done = 1'b0;
    chk("R3 redirect", {31'd0, redirect}, 32'd1);
    chk("R3 handler pc", redirect_pc, HND);
    rd(5'd14, v); chk("R4 epc saved", v, 32'h0040_0010);
    rd(5'd12, v); chk("R5 ie cleared", v, 32'd0);
    rd(5'd13, v); chk("R6 irq code and R7 pend bit", v, 32'h0000_0400);
    tick();
    chk("R11 redirect one cycle", {31'd0, redirect}, 32'd0);
  endtask

  task automatic t_ack();
    ack_cmd = 1'b1;
    tick();
    chk("R10 iack pulse", {31'd0, iack}, 32'd1);
    tick();
    chk("R10 iack single", {31'd0, iack}, 32'd0);
    dev_irq = 1'b0;
    tick();
    chk("R10 held no repeat", {31'd0, iack}, 32'd0);
    ack_cmd = 1'b0;
    tick();
  endtask

  task automatic t_pend();
    logic [31:0] v;
    dev_pend = 8'h11;
    tick();
    dev_pend = 8'h00;
    wr(5'd13, 32'h0000_04FF);
    rd(5'd13, v); chk("R7 w1c selective", v, 32'h0000_1100);
    dev_pend = 8'h10;
    wr(5'd13, 32'h0000_1100);
    dev_pend = 8'h00;
    rd(5'd13, v); chk("R7 set beats clear", v, 32'h0000_1000);
    wr(5'd13, 32'h0000_1000);
    rd(5'd13, v); chk("R7 cleared", v, 32'h0000_0000);
  endtask

  task automatic t_eret();
    logic [31:0] v;
    eret = 1'b1;
    tick();
    eret = 1'b0;
    chk("R8 redirect", {31'd0, redirect}, 32'd1);
    chk("R8 epc target", redirect_pc, 32'h0040_0010);
    rd(5'd12, v); chk("R8 ie set", v, 32'd1);
    tick();
  endtask

  task automatic t_ovf();
    logic [31:0] v;
    wr(5'd12, 32'd0);
    instr_done = 1'b1; ovf_exc = 1'b1; next_pc = 32'h0000_0500;
    tick();
    instr_done = 1'b0; ovf_exc = 1'b0;
    chk("R6 ovf redirect", {31'd0, redirect}, 32'd1);
    chk("R6 ovf handler", redirect_pc, HND);
    rd(5'd13, v); chk("R6 ovf code", v & 32'hFF, 32'h30);
    rd(5'd14, v); chk("R4 ovf epc", v, 32'h0000_0500);
    tick();
  endtask

  task automatic t_conflict();
    logic [31:0] v;
    wr(5'd12, 32'd1);
    dev_irq = 1'b1; instr_done = 1'b1; eret = 1'b1; next_pc = 32'h0000_0900;
    tick();
    dev_irq = 1'b0; instr_done = 1'b0; eret = 1'b0;
    chk("R9 entry wins pc", redirect_pc, HND);
    rd(5'd12, v); chk("R9 ie stays clear", v, 32'd0);
    rd(5'd13, v); chk("R6 irq code", v & 32'hFF, 32'h00);
    tick();
  endtask

  initial begin
    #10;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_regs();
    t_irq_masked();
    t_irq_taken();
    t_ack();
    t_pend();
    t_eret();
    t_ovf();
    t_conflict();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #40000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule